// File: doc/BRIEF.md
# Test and Debug Mode Sequencer

This block turns the levels seen on three control pins (the reset pin, the program pin and the TEST1 input) into one operating mode of a small microcontroller. It then runs the sequence that mode needs. Each pin arrives as a 2-bit level code that the electrical level detector produces. A new mode is sampled once per machine cycle of `CYC_LEN` clocks and takes effect at the cycle boundary. Every mode entry clears the address counters.

The block has two ways to dump the internal ROM onto port 0:
- **Cycle-paced dump:** the address advances once per machine cycle and is valid from the leading edge of the address strobe.
- **TEST1-stepped dump:** each synchronized falling edge of TEST1 advances the address by one.

The block has three other modes:
- **External-page execution:** port 0 drives a one-page address while the address strobe is high, then turns to input. The byte read back is captured at the end of the cycle.
- **Opcode injection:** port 1 is enabled as the opcode source.
- **Power-on clear and normal run:** the block keeps its port controls idle.

The CPU core, the ROM array and the level detector sit outside the block.

Top module: `tmode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode_o` is 0, and `ale_o`, `p0_oe_o`, `p1_opc_en_o`, `rom_addr_o` and `ext_byte_o` are all 0.
- R2: Level codes are: 00 low, 01 normal high, 10 elevated, 11 treated as normal high. A reset pin at normal high (01 or 11), with neither other pin elevated, selects power-on clear (`mode_o` = 1). A reset pin at low, with neither other pin elevated, selects normal run (`mode_o` = 0).
- R3: Reset, program and TEST1 all elevated select the cycle-paced dump (`mode_o` = 2). In this mode `rom_addr_o` starts at 0 and rises by one at each rising edge of `ale_o`. Port 0 drives `rom_data_i` with `p0_oe_o` = 1.
- R4: Reset and program elevated, with TEST1 not elevated, select the TEST1-stepped dump (`mode_o` = 3). Each falling edge of TEST1 (from normal high to low) raises `rom_addr_o` by exactly one, and a rising edge has no effect. Port 0 drives `rom_data_i`.
- R5: Reset low, program elevated and TEST1 not elevated select external-page execution (`mode_o` = 4). While `ale_o` is high, `p0_oe_o` is 1 and `p0_out_o` carries the page address, which starts at 0 and advances once per cycle. At the end of each cycle `p0_in_i` is captured into `ext_byte_o`.
- R6: Reset elevated with neither other pin elevated selects opcode injection (`mode_o` = 5). In this mode `p1_opc_en_o` = 1, and `p0_oe_o` and `ale_o` are 0.
- R7: Any combination not listed in R2 to R6 selects normal run (`mode_o` = 0). This includes an elevated level on a pin that a listed mode treats as don't-care.
- R8: A change of the decoded mode reaches `mode_o` only at a machine-cycle boundary. In the strobed modes, that boundary is the clock edge that raises `ale_o`.
- R9: Every mode entry clears the dump address to 0. The dump address wraps from 2^`ROM_AW`-1 to 0.
- R10: The page address is `PAGE_AW` bits wide and wraps from 255 to 0 at the defaults.
- R11: In modes 2 and 4, `ale_o` is high for the first `ALE_PH` clocks of each `CYC_LEN`-clock cycle. In every other mode it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_lvl_i | input | 2 | Level code of the reset pin |
| prog_lvl_i | input | 2 | Level code of the program pin |
| t1_lvl_i | input | 2 | Level code of TEST1 |
| rom_data_i | input | DW | Byte read from internal ROM at `rom_addr_o` |
| p0_in_i | input | DW | Port 0 input value |
| mode_o | output | 3 | Active mode code |
| ale_o | output | 1 | Address strobe |
| rom_addr_o | output | ROM_AW | Dump address to internal ROM |
| p0_out_o | output | DW | Port 0 output value |
| p0_oe_o | output | 1 | Port 0 output enable |
| p1_opc_en_o | output | 1 | Port 1 selected as opcode source |
| ext_byte_o | output | DW | Last byte captured from port 0 in external-page mode |

## Verification
Results are due at different times after a stimulus:
- **Level change:** the new mode can appear up to `CYC_LEN` clocks later. The bench waits at least that long, or it aligns to a rising edge of `ale_o` so that it knows the exact boundary and can check the old mode one clock before it.
- **Cycle-paced dump and external address:** both are checked at each `ale_o` rising edge, which comes every `CYC_LEN` clocks.
- **Captured external byte:** it is checked at the following rising edge.
- **TEST1 step:** the increment lands `SYNC_STAGES`+1 clocks after the level change. The bench samples `SYNC_STAGES`+3 clocks later.

The bench also checks that an opposite edge caused no step. All samples are taken on the falling clock edge.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
   typedef enum logic [1:0] {
      LVL_LOW  = 2'b00,
      LVL_NORM = 2'b01,
      LVL_HV   = 2'b10,
      LVL_RSV  = 2'b11
   } lvl_e;

   typedef enum logic [2:0] {
      M_RUN       = 3'd0,
      M_CLEAR     = 3'd1,
      M_DUMP_CYC  = 3'd2,
      M_DUMP_STEP = 3'd3,
      M_EXT       = 3'd4,
      M_OPC       = 3'd5
   } mode_e;

   function automatic logic is_hv(logic [1:0] l);
      return l == LVL_HV;
   endfunction

   function automatic logic is_high(logic [1:0] l);
      return (l == LVL_NORM) || (l == LVL_RSV);
   endfunction
endpackage

// File: rtl/tmc_decode.sv
module tmc_decode
   import tmc_pkg::*;
(
   input  logic [1:0] rst_lvl,
   input  logic [1:0] prog_lvl,
   input  logic [1:0] t1_lvl,
   output mode_e      mode
);
   always_comb begin
      mode = M_RUN;
      if (is_hv(rst_lvl)) begin
         if (is_hv(prog_lvl))
            mode = is_hv(t1_lvl) ? M_DUMP_CYC : M_DUMP_STEP;
         else if (!is_hv(t1_lvl))
            mode = M_OPC;
      end else if (is_high(rst_lvl)) begin
         if (!is_hv(prog_lvl) && !is_hv(t1_lvl))
            mode = M_CLEAR;
      end else begin
         if (is_hv(prog_lvl) && !is_hv(t1_lvl))
            mode = M_EXT;
      end
   end
endmodule

// File: rtl/tmc_fall_det.sv
module tmc_fall_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmc_fall_det: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= din;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];
   end

   assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/tmc_seq.sv
module tmc_seq
   import tmc_pkg::*;
#(
   parameter int CYC_LEN = 5,
   parameter int ALE_PH  = 2,
   parameter int ROM_AW  = 8,
   parameter int PAGE_AW = 8,
   parameter int DW      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  mode_e              mode_next,
   input  logic               step,
   input  logic [DW-1:0]      p0_in,
   output mode_e              mode_q,
   output logic               ale,
   output logic [ROM_AW-1:0]  dump_addr,
   output logic [PAGE_AW-1:0] page_addr,
   output logic [DW-1:0]      ext_byte
);
   localparam int PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);
   localparam logic [PH_W-1:0] PH_ALE  = PH_W'(ALE_PH);

   logic [PH_W-1:0] phase;
   logic            boundary;
   logic            mode_chg;

   assign boundary = (phase == PH_LAST);
   assign mode_chg = boundary && (mode_next != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= '0;
         mode_q <= M_RUN;
      end else begin
         phase <= boundary ? '0 : phase + 1'b1;
         if (boundary) mode_q <= mode_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dump_addr <= '0;
      end else if (mode_chg) begin
         dump_addr <= '0;
      end else if ((mode_q == M_DUMP_CYC && boundary) ||
                   (mode_q == M_DUMP_STEP && step)) begin
         dump_addr <= dump_addr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_addr <= '0;
         ext_byte  <= '0;
      end else begin
         if (mode_chg)
            page_addr <= '0;
         else if (boundary && mode_q == M_EXT)
            page_addr <= page_addr + 1'b1;
         if (boundary && mode_q == M_EXT)
            ext_byte <= p0_in;
      end
   end

   assign ale = ((mode_q == M_DUMP_CYC) || (mode_q == M_EXT)) && (phase < PH_ALE);
endmodule

// File: rtl/tmode_ctrl.sv
module tmode_ctrl
   import tmc_pkg::*;
#(
   parameter int CYC_LEN     = 5,
   parameter int ALE_PH      = 2,
   parameter int ROM_AW      = 8,
   parameter int PAGE_AW     = 8,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        rst_lvl_i,
   input  logic [1:0]        prog_lvl_i,
   input  logic [1:0]        t1_lvl_i,
   input  logic [DW-1:0]     rom_data_i,
   input  logic [DW-1:0]     p0_in_i,
   output logic [2:0]        mode_o,
   output logic              ale_o,
   output logic [ROM_AW-1:0] rom_addr_o,
   output logic [DW-1:0]     p0_out_o,
   output logic              p0_oe_o,
   output logic              p1_opc_en_o,
   output logic [DW-1:0]     ext_byte_o
);
   generate
      if (CYC_LEN < 2) begin : g_bad_cyc
         $error("tmode_ctrl: CYC_LEN must be at least 2");
      end
      if (ALE_PH < 1 || ALE_PH >= CYC_LEN) begin : g_bad_ale
         $error("tmode_ctrl: ALE_PH must lie in 1..CYC_LEN-1");
      end
      if (PAGE_AW > DW || PAGE_AW < 1) begin : g_bad_page
         $error("tmode_ctrl: PAGE_AW must lie in 1..DW");
      end
      if (ROM_AW < 1 || ROM_AW > 16) begin : g_bad_rom
         $error("tmode_ctrl: ROM_AW must lie in 1..16");
      end
   endgenerate

   mode_e               mode_next;
   mode_e               mode_q;
   logic                t1_fall;
   logic                ale;
   logic [PAGE_AW-1:0]  page_addr;

   tmc_decode u_decode (
      .rst_lvl  (rst_lvl_i),
      .prog_lvl (prog_lvl_i),
      .t1_lvl   (t1_lvl_i),
      .mode     (mode_next)
   );

   tmc_fall_det #(.STAGES(SYNC_STAGES)) u_t1_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (is_high(t1_lvl_i)),
      .fall  (t1_fall)
   );

   tmc_seq #(
      .CYC_LEN (CYC_LEN),
      .ALE_PH  (ALE_PH),
      .ROM_AW  (ROM_AW),
      .PAGE_AW (PAGE_AW),
      .DW      (DW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_next (mode_next),
      .step      (t1_fall),
      .p0_in     (p0_in_i),
      .mode_q    (mode_q),
      .ale       (ale),
      .dump_addr (rom_addr_o),
      .page_addr (page_addr),
      .ext_byte  (ext_byte_o)
   );

   always_comb begin
      p0_out_o = '0;
      p0_oe_o  = 1'b0;
      case (mode_q)
         M_DUMP_CYC, M_DUMP_STEP: begin
            p0_out_o = rom_data_i;
            p0_oe_o  = 1'b1;
         end
         M_EXT: begin
            p0_oe_o  = ale;
            p0_out_o = ale ? DW'(page_addr) : '0;
         end
         default: ;
      endcase
   end

   assign mode_o      = mode_q;
   assign ale_o       = ale;
   assign p1_opc_en_o = (mode_q == M_OPC);
endmodule

// File: rtl/tmc_chk.sv
module tmc_chk #(
   parameter int ROM_AW = 8,
   parameter int DW     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DW-1:0]     rom_data_i,
   input logic [2:0]        mode_o,
   input logic              ale_o,
   input logic [ROM_AW-1:0] rom_addr_o,
   input logic [DW-1:0]     p0_out_o,
   input logic              p0_oe_o,
   input logic              p1_opc_en_o
);
   // R11
   ale_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale_o |-> (mode_o == 3'd2 || mode_o == 3'd4));

   // R3
   dump_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd2 || mode_o == 3'd3) |-> (p0_oe_o && p0_out_o == rom_data_i));

   // R9
   entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != $past(mode_o)) |-> (rom_addr_o == '0));

   // R3
   cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd2 && $past(mode_o) == 3'd2 && rom_addr_o != $past(rom_addr_o))
      |-> (rom_addr_o == ROM_AW'($past(rom_addr_o) + 1'b1) && ale_o && !$past(ale_o)));

   // R4
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd3 && $past(mode_o) == 3'd3)
      |-> (rom_addr_o == $past(rom_addr_o) ||
           rom_addr_o == ROM_AW'($past(rom_addr_o) + 1'b1)));

   // R5
   ext_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4) |-> (p0_oe_o == ale_o));

   // R6
   opc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd5) |-> (p1_opc_en_o && !p0_oe_o && !ale_o));
endmodule

bind tmode_ctrl tmc_chk #(.ROM_AW(ROM_AW), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rom_data_i  (rom_data_i),
   .mode_o      (mode_o),
   .ale_o       (ale_o),
   .rom_addr_o  (rom_addr_o),
   .p0_out_o    (p0_out_o),
   .p0_oe_o     (p0_oe_o),
   .p1_opc_en_o (p1_opc_en_o)
);

// File: tb/test_tmode_ctrl.sv
`timescale 1ns/1ps
module test_tmode_ctrl;
   localparam int CYC_LEN     = 5;
   localparam int ALE_PH      = 2;
   localparam int ROM_AW      = 8;
   localparam int PAGE_AW     = 8;
   localparam int DW          = 8;
   localparam int SYNC_STAGES = 2;

   localparam logic [1:0] LO = 2'b00, NH = 2'b01, HV = 2'b10, RS = 2'b11;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [1:0]        rst_lvl, prog_lvl, t1_lvl;
   logic [DW-1:0]     rom_data, p0_in;
   logic [2:0]        mode;
   logic              ale, p0_oe, p1_opc;
   logic [ROM_AW-1:0] rom_addr;
   logic [DW-1:0]     p0_out, ext_byte;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   function automatic logic [DW-1:0] rom_f(logic [ROM_AW-1:0] a);
      return DW'(a * 7 + 3);
   endfunction

   function automatic logic [DW-1:0] ext_f(int a);
      return DW'(a) ^ 8'hA5;
   endfunction

   function automatic int exp_mode(logic [1:0] r, logic [1:0] p, logic [1:0] t);
      bit rh = (r == HV), ph = (p == HV), th = (t == HV);
      if (r == LO)                   return (ph && !th) ? 4 : 0;
      if (!rh)                       return (!ph && !th) ? 1 : 0;
      if (ph && th)                  return 2;
      if (ph)                        return 3;
      if (!th)                       return 5;
      return 0;
   endfunction

   assign rom_data = rom_f(rom_addr);

   tmode_ctrl #(
      .CYC_LEN(CYC_LEN), .ALE_PH(ALE_PH), .ROM_AW(ROM_AW),
      .PAGE_AW(PAGE_AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)
   ) i_tmode_ctrl (
      .clk(clk), .rst_n(rst_n),
      .rst_lvl_i(rst_lvl), .prog_lvl_i(prog_lvl), .t1_lvl_i(t1_lvl),
      .rom_data_i(rom_data), .p0_in_i(p0_in),
      .mode_o(mode), .ale_o(ale), .rom_addr_o(rom_addr),
      .p0_out_o(p0_out), .p0_oe_o(p0_oe), .p1_opc_en_o(p1_opc),
      .ext_byte_o(ext_byte)
   );

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_lvl(logic [1:0] r, logic [1:0] p, logic [1:0] t);
      rst_lvl = r; prog_lvl = p; t1_lvl = t;
   endtask

   task automatic wait_mode(int m, string req);
      for (int i = 0; i < 3 * CYC_LEN && mode != 3'(m); i++) tick(1);
      check(mode == 3'(m), req, mode, m);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0;
      set_lvl(LO, LO, LO);
      p0_in = '0;
      tick(3);
      // R1 reset state
      check(mode == 0,     "R1 mode",     mode, 0);
      check(ale == 0,      "R1 ale",      ale, 0);
      check(p0_oe == 0,    "R1 p0_oe",    p0_oe, 0);
      check(p1_opc == 0,   "R1 p1_opc",   p1_opc, 0);
      check(rom_addr == 0, "R1 addr",     rom_addr, 0);
      check(ext_byte == 0, "R1 ext_byte", ext_byte, 0);
      rst_n = 1'b1;
      tick(2);

      // R2 power-on clear and normal run
      set_lvl(NH, LO, NH); tick(2 * CYC_LEN);
      check(mode == 1, "R2 clear 01", mode, 1);
      set_lvl(RS, NH, LO); tick(2 * CYC_LEN);
      check(mode == 1, "R2 clear 11", mode, 1);
      set_lvl(LO, NH, RS); tick(2 * CYC_LEN);
      check(mode == 0, "R2 run", mode, 0);

      // R7 unlisted combinations
      set_lvl(NH, HV, LO); tick(2 * CYC_LEN);
      check(mode == 0, "R7 norm+prog hv", mode, 0);
      set_lvl(LO, HV, HV); tick(2 * CYC_LEN);
      check(mode == 0, "R7 low+hv+hv", mode, 0);
      set_lvl(HV, LO, HV); tick(2 * CYC_LEN);
      check(mode == 0, "R7 hv+low+hv", mode, 0);

      // R3 cycle-paced dump, R11 strobe shape, R9 wrap
      set_lvl(HV, HV, HV);
      wait_mode(2, "R3 enter");
      for (int k = 0; k < 260; k++) begin
         check(ale == 1, "R11 ale high at start", ale, 1);
         check(rom_addr == ROM_AW'(k), "R3/R9 dump addr", rom_addr, k % 256);
         check(p0_oe == 1 && p0_out == rom_f(ROM_AW'(k)), "R3 p0 data", p0_out, rom_f(ROM_AW'(k)));
         tick(ALE_PH - 1);
         check(ale == 1, "R11 ale width", ale, 1);
         tick(1);
         check(ale == 0, "R11 ale low", ale, 0);
         tick(CYC_LEN - ALE_PH);
      end

      // R8 boundary timing, R6 opcode mode, R9 clear on entry
      set_lvl(HV, LO, LO);
      tick(CYC_LEN - 1);
      check(mode == 2, "R8 old mode before boundary", mode, 2);
      tick(1);
      check(mode == 5, "R8 new mode at boundary", mode, 5);
      check(p1_opc == 1, "R6 p1 opcode enable", p1_opc, 1);
      check(p0_oe == 0 && ale == 0, "R6 port0 idle", p0_oe, 0);
      check(rom_addr == 0, "R9 cleared on entry", rom_addr, 0);

      // R4 TEST1-stepped dump
      set_lvl(HV, HV, NH);
      wait_mode(3, "R4 enter");
      check(rom_addr == 0, "R9 step entry addr", rom_addr, 0);
      for (int i = 1; i <= 260; i++) begin
         t1_lvl = LO;
         tick(SYNC_STAGES + 3);
         check(rom_addr == ROM_AW'(i), "R4 fall steps once", rom_addr, i % 256);
         check(p0_out == rom_f(ROM_AW'(i)), "R4 p0 data", p0_out, rom_f(ROM_AW'(i)));
         t1_lvl = NH;
         tick(SYNC_STAGES + 3);
         check(rom_addr == ROM_AW'(i), "R4 rise ignored", rom_addr, i % 256);
      end

      // R9 re-entry into cycle dump clears
      set_lvl(HV, HV, HV);
      wait_mode(2, "R9 reenter");
      check(rom_addr == 0, "R9 reentry addr", rom_addr, 0);

      // R5 external page, R10 wrap
      set_lvl(LO, HV, LO);
      wait_mode(4, "R5 enter");
      for (int k = 0; k < 300; k++) begin
         check(ale == 1 && p0_oe == 1, "R5 addr phase drive", p0_oe, 1);
         check(p0_out == DW'(k % 256), "R10 page addr", p0_out, k % 256);
         if (k > 0)
            check(ext_byte == ext_f((k - 1) % 256), "R5 captured byte", ext_byte, ext_f((k - 1) % 256));
         p0_in = ext_f(k % 256);
         tick(ALE_PH);
         check(p0_oe == 0, "R5 data phase input", p0_oe, 0);
         tick(CYC_LEN - ALE_PH);
      end

      // R2/R7 random level combinations
      for (int n = 0; n < 40; n++) begin
         logic [1:0] r, p, t;
         r = 2'($urandom_range(0, 3));
         p = 2'($urandom_range(0, 3));
         t = 2'($urandom_range(0, 3));
         set_lvl(r, p, t);
         tick(2 * CYC_LEN);
         check(mode == 3'(exp_mode(r, p, t)), "R7 random decode", mode, exp_mode(r, p, t));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule